// File: doc/BRIEF.md
# Set-Associative Tag Store with Switchable Victim Selection

This block holds the tags, valid bits and replacement history of an N-way set-associative cache. Each request names a set and a tag. All ways of that set compare their stored tag against the request tag at once. A way counts as a match only when its valid bit is also set. The block answers one clock later. The answer says hit or miss and gives a way number: the matching way on a hit, or the way a fill would take on a miss.

The surrounding controller issues two kinds of request. A lookup asks whether the block is present. A fill installs the tag after the controller has fetched the line. Empty ways in a set always fill first, lowest number first. Once every way in a set is occupied, a two-bit mode input picks the eviction rule:
- least recently used,
- oldest fill,
- pseudo-random,
- most recently used (fetch-and-discard).

The mode can change between any two requests. Replacement history is updated on every hit and on every fill, so switching modes never leaves stale state. The data array, line transfers and write policy are outside this block. With one way the block is a direct-mapped tag store.

Top module: `setassoc_tagstore`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces exactly one response, with `rsp_valid` high, in the following cycle. No response appears without a request. On a hit, `rsp_way` is the way whose stored tag equals `req_tag`.
- R2: After reset every way is invalid, and an invalid way never hits, even if its stored tag (zero after reset) equals the request tag.
- R3: On a miss in a set that has an invalid way, the victim is the lowest-numbered invalid way. A fill writes the tag there and marks the way valid.
- R4: With `policy` = 0 (least recently used) and the set full, the victim is the way whose last hit or fill is oldest. Ways never touched since reset count as older the lower their number, so way 0 is the first victim.
- R5: With `policy` = 1 (first in, first out) and the set full, the victim is the way filled earliest. Hits do not change this order.
- R6: With `policy` = 3 (most recently used) and the set full, the victim is the way most recently hit or filled.
- R7: With `policy` = 2 (pseudo-random) and the set full, the victim is some way of the set, taken from a free-running 16-bit LFSR modulo the way count. The newly filled tag then hits at the reported way.
- R8: A fill whose tag already hits in the set is answered as a hit at that way and allocates no second copy. At most one way of a set ever matches.
- R9: A lookup that misses changes no state. A repeated missing lookup reports the same victim, and no valid bit changes.
- R10: A lookup miss reports in `rsp_way` the way that a fill issued next, under the same policy, would take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_fill | input | 1 | 1 = fill, 0 = lookup |
| req_set | input | IDX_W (4) | Set index of the request |
| req_tag | input | TAG_W (20) | Tag of the request |
| policy | input | 2 | 0 LRU, 1 FIFO, 2 random, 3 MRU |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_way | output | WAY_W (2) | Hitting way, or victim way on a miss |

## Verification
Corrupted recency or fill-order history stays hidden while a set still has empty ways. It shows up only on the first miss in a full set, as a wrong `rsp_way` one cycle after that request. The bench therefore fills each set completely and then interleaves hits with misses before checking victims. A lost or stuck valid bit shows up on the next lookup of that set, as a wrong hit flag or a wrong victim. After every random-mode fill, the new tag is looked up again so that the reported way is confirmed at the ports.

// File: rtl/stl_pkg.sv
package stl_pkg;

    // Replacement mode encoding at the policy input
    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2,
        POL_MRU  = 2'd3
    } repl_pol_e;

endpackage

// File: rtl/stl_lfsr.sv
module stl_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] lfsr_d, lfsr_q;
    logic         fb;

    // Taps 16,14,13,11: maximal-length sequence, advances every cycle
    always_comb begin
        fb     = lfsr_q[W-1] ^ lfsr_q[W-3] ^ lfsr_q[W-4] ^ lfsr_q[W-6];
        lfsr_d = {lfsr_q[W-2:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= W'(SEED);
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

endmodule

// File: rtl/stl_tag_compare.sv
module stl_tag_compare #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    // One comparator per way, all evaluated at once
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_vld[w] && (set_tag[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/stl_victim_pick.sv
module stl_victim_pick
    import stl_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0]            set_vld,
    input  logic [WAYS-1:0][AGE_W-1:0] use_age,
    input  logic [WAYS-1:0][AGE_W-1:0] fill_age,
    input  logic [15:0]                rnd,
    input  repl_pol_e                  policy,
    output logic [WAY_W-1:0]           victim
);

    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic             inv_found;
    logic [WAY_W-1:0] inv_way, lru_way, mru_way, fifo_way, rnd_way;

    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        // Descending scan so the lowest invalid way wins
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_vld[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    // Ages form a permutation per set, so each scan finds exactly one way
    always_comb begin
        lru_way  = '0;
        mru_way  = '0;
        fifo_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (use_age[w]  == OLDEST)        lru_way  = WAY_W'(w);
            if (use_age[w]  == '0)            mru_way  = WAY_W'(w);
            if (fill_age[w] == OLDEST)        fifo_way = WAY_W'(w);
        end
    end

    if (WAYS > 1) begin : g_rnd
        assign rnd_way = WAY_W'(rnd % 16'(WAYS));
    end else begin : g_rnd_dm
        assign rnd_way = '0;
    end

    always_comb begin
        if (inv_found) begin
            victim = inv_way;
        end else begin
            unique case (policy)
                POL_LRU:  victim = lru_way;
                POL_FIFO: victim = fifo_way;
                POL_RAND: victim = rnd_way;
                POL_MRU:  victim = mru_way;
                default:  victim = lru_way;
            endcase
        end
    end

endmodule

// File: rtl/setassoc_tagstore.sv
module setassoc_tagstore
    import stl_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int AGE_W = WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_fill,
    input  logic [IDX_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [1:0]       policy,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way
);

    typedef logic [WAYS-1:0][AGE_W-1:0] age_vec_t;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] use_age;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] fill_age;
        logic                                 rsp_v;
        logic                                 rsp_hit;
        logic [WAY_W-1:0]                     rsp_way;
    } state_t;

    state_t st_d, st_q;

    // Touched way becomes age 0; ways younger than its old age grow older
    function automatic age_vec_t touch(age_vec_t a, logic [WAY_W-1:0] w);
        age_vec_t         r;
        logic [AGE_W-1:0] old;
        old = a[w];
        for (int i = 0; i < WAYS; i++) begin
            if (WAY_W'(i) == w)   r[i] = '0;
            else if (a[i] < old)  r[i] = a[i] + AGE_W'(1);
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    // Way 0 starts as the oldest in both orderings
    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                r.use_age[s][w]  = AGE_W'(WAYS - 1 - w);
                r.fill_age[s][w] = AGE_W'(WAYS - 1 - w);
            end
        end
        return r;
    endfunction

    logic [15:0]      rnd;
    logic [WAYS-1:0]  hit_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    repl_pol_e        pol;

    assign pol = repl_pol_e'(policy);

    stl_lfsr #(.W(16)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    stl_tag_compare #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
        .set_tag (st_q.tag[req_set]),
        .set_vld (st_q.vld[req_set]),
        .tag     (req_tag),
        .hit_vec (hit_vec),
        .hit     (hit),
        .hit_way (hit_way)
    );

    stl_victim_pick #(.WAYS(WAYS)) u_vic (
        .set_vld  (st_q.vld[req_set]),
        .use_age  (st_q.use_age[req_set]),
        .fill_age (st_q.fill_age[req_set]),
        .rnd      (rnd),
        .policy   (pol),
        .victim   (victim)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsp_v   = req_valid;
        st_d.rsp_hit = 1'b0;
        st_d.rsp_way = '0;
        if (req_valid) begin
            if (hit) begin
                st_d.rsp_hit          = 1'b1;
                st_d.rsp_way          = hit_way;
                st_d.use_age[req_set] = touch(st_q.use_age[req_set], hit_way);
            end else begin
                st_d.rsp_way = victim;
                if (req_fill) begin
                    st_d.tag[req_set][victim]  = req_tag;
                    st_d.vld[req_set][victim]  = 1'b1;
                    st_d.use_age[req_set]      = touch(st_q.use_age[req_set], victim);
                    st_d.fill_age[req_set]     = touch(st_q.fill_age[req_set], victim);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_way   = st_q.rsp_way;

    logic [SETS*WAYS-1:0] vld_flat;
    assign vld_flat = st_q.vld;

endmodule

// File: rtl/stl_tagstore_chk.sv
module stl_tagstore_chk #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_fill,
    input logic [IDX_W-1:0]     req_set,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [WAY_W-1:0]     rsp_way,
    input logic [SETS*WAYS-1:0] vld_flat,
    input logic [WAYS-1:0]      hit_vec
);

    logic [SETS-1:0][WAYS-1:0] vld2;
    assign vld2 = vld_flat;

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld_flat == '0));

    assert_hit_way_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> vld2[$past(req_set)][rsp_way]);

    assert_fill_marks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fill) |=> vld2[$past(req_set)][rsp_way]);

    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_miss_keeps_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !$past(req_fill)) |-> $stable(vld_flat));

endmodule

bind setassoc_tagstore stl_tagstore_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_fill  (req_fill),
    .req_set   (req_set),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .vld_flat  (vld_flat),
    .hit_vec   (hit_vec)
);

// File: tb/sim_setassoc_tagstore.sv
module sim_setassoc_tagstore;

    localparam int SETS  = 16;
    localparam int WAYS  = 4;
    localparam int TAG_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_fill = 1'b0;
    logic [3:0]       req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [1:0]       policy = 2'd0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [1:0]       rsp_way;

    always #5 clk = ~clk;

    setassoc_tagstore #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u0 (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_fill (req_fill),
        .req_set (req_set), .req_tag (req_tag), .policy (policy),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_way (rsp_way)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        bit    hit;
        int    way;
        bit    any_way;
        string req;
    } exp_t;
    exp_t sbq[$];

    // Reference model: recency lists, index 0 = most recent
    bit               mv  [SETS][WAYS];
    logic [TAG_W-1:0] mt  [SETS][WAYS];
    int               ord [SETS][WAYS];
    int               ford[SETS][WAYS];

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            for (int i = 0; i < WAYS; i++) begin
                mv[s][i]   = 0;
                mt[s][i]   = '0;
                ord[s][i]  = WAYS - 1 - i;
                ford[s][i] = WAYS - 1 - i;
            end
        end
    endtask

    task automatic bump(input bit fifo_list, input int s, input int w);
        int p = 0;
        for (int i = 0; i < WAYS; i++) begin
            if ((fifo_list ? ford[s][i] : ord[s][i]) == w) p = i;
        end
        for (int i = p; i > 0; i--) begin
            if (fifo_list) ford[s][i] = ford[s][i-1];
            else           ord[s][i]  = ord[s][i-1];
        end
        if (fifo_list) ford[s][0] = w;
        else           ord[s][0]  = w;
    endtask

    function automatic int m_find(input int s, input logic [TAG_W-1:0] t);
        for (int i = 0; i < WAYS; i++) begin
            if (mv[s][i] && mt[s][i] == t) return i;
        end
        return -1;
    endfunction

    function automatic int m_victim(input int s, input int pol);
        for (int i = 0; i < WAYS; i++) begin
            if (!mv[s][i]) return i;
        end
        case (pol)
            0: return ord[s][WAYS-1];
            1: return ford[s][WAYS-1];
            3: return ord[s][0];
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // Driver: computes expectation, pushes it, issues one request
    task automatic access(input bit fill, input int s, input logic [TAG_W-1:0] t,
                          input int pol, input string req);
        exp_t e;
        int   hw, vw;
        hw = m_find(s, t);
        vw = m_victim(s, pol);
        e.req     = req;
        e.hit     = (hw >= 0);
        e.way     = (hw >= 0) ? hw : vw;
        e.any_way = (hw < 0) && (vw < 0);
        @(negedge clk);
        req_valid = 1'b1;
        req_fill  = fill;
        req_set   = 4'(s);
        req_tag   = t;
        policy    = 2'(pol);
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (hw >= 0) begin
            bump(0, s, hw);
        end else if (fill) begin
            if (vw < 0) vw = int'(rsp_way);
            mv[s][vw] = 1;
            mt[s][vw] = t;
            bump(0, s, vw);
            bump(1, s, vw);
        end
    endtask

    // Monitor: pops and compares each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                check(0, "R1", "response without request");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.any_way)
                    check(rsp_hit == e.hit && int'(rsp_way) < WAYS, e.req,
                          $sformatf("hit=%0d way=%0d exp hit=%0d way<%0d",
                                    rsp_hit, rsp_way, e.hit, WAYS));
                else
                    check(rsp_hit == e.hit && int'(rsp_way) == e.way, e.req,
                          $sformatf("hit=%0d way=%0d exp hit=%0d way=%0d",
                                    rsp_hit, rsp_way, e.hit, e.way));
            end
        end
    end

    task automatic fill_set(input int s, input int base, input int pol);
        for (int i = 0; i < WAYS; i++) access(1, s, TAG_W'(base + i), pol, "R3");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid=%0d exp 0 in reset", rsp_valid));
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", $sformatf("rsp_valid=%0d exp 0 idle", rsp_valid));

        // R2: zero tag in fresh set must miss
        access(0, 0, '0, 0, "R2");
        // R3/R10: cold lookup and fills into invalid ways
        access(0, 1, 20'h10, 0, "R10");
        fill_set(1, 20'h10, 0);
        access(0, 1, 20'h12, 0, "R1");
        access(0, 1, 20'h10, 0, "R1");
        // R4: LRU victim, R9 repeated miss same victim
        access(0, 1, 20'h20, 0, "R4");
        access(0, 1, 20'h21, 0, "R9");
        access(1, 1, 20'h20, 0, "R4");
        access(0, 1, 20'h11, 0, "R4");
        access(0, 1, 20'h13, 0, "R4");
        access(1, 1, 20'h22, 0, "R4");
        access(0, 1, 20'h22, 0, "R1");

        // R5: FIFO ignores hits
        fill_set(2, 20'h100, 1);
        access(0, 2, 20'h100, 1, "R5");
        access(0, 2, 20'h101, 1, "R5");
        access(1, 2, 20'h200, 1, "R5");
        access(1, 2, 20'h201, 1, "R5");
        access(0, 2, 20'h999, 1, "R10");
        access(1, 2, 20'h202, 1, "R5");

        // R6: MRU evicts the last touched way
        fill_set(3, 20'h300, 3);
        access(0, 3, 20'h302, 3, "R6");
        access(1, 3, 20'h3A0, 3, "R6");
        access(0, 3, 20'h300, 3, "R6");
        access(1, 3, 20'h3A1, 3, "R6");
        access(0, 3, 20'h3A1, 3, "R6");

        // R7: random fills land somewhere, then hit there
        fill_set(4, 20'h400, 2);
        for (int k = 0; k < 6; k++) begin
            access(1, 4, TAG_W'(20'h4A0 + k), 2, "R7");
            access(0, 4, TAG_W'(20'h4A0 + k), 2, "R7");
        end

        // R8: refill of a present tag is a hit, nothing displaced
        fill_set(5, 20'h500, 0);
        access(1, 5, 20'h502, 0, "R8");
        for (int i = 0; i < WAYS; i++) access(0, 5, TAG_W'(20'h500 + i), 0, "R8");

        // Mode switch on a set with shared history
        access(1, 1, 20'h777, 1, "R5");
        access(1, 1, 20'h778, 3, "R6");
        access(1, 1, 20'h779, 0, "R4");
        // Untouched set still cold
        access(0, 9, 20'h500, 0, "R3");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R1", $sformatf("pending=%0d exp 0", sbq.size()));
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1: watchdog expired, actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule